// File: doc/BRIEF.md
# TV Load Detection Strobe Controller

This block runs on the pixel clock beside a video encoder and helps software find out whether a television cable is plugged into the analog video output. On every video line it drives an active-low detection strobe to the analog output stage. The strobe is placed between two programmable pixel positions, which are counted from the start of horizontal sync. An external comparator senses the load. Its output is captured in two steps. First it is latched privately at the start of each sync. Then that latched value becomes the visible load status when the strobe returns high. Whenever the visible status changes, a one-cycle interrupt fires, so the system learns that a cable was connected or removed.

The block also forwards a coupling-mode bit to the analog stage (0 for DC coupled, 1 for AC coupled) so the stage can adjust its thresholds. The start position, the stop position and the coupling bit can only be written while detection is disabled. Writes made while it is enabled are ignored.

A state machine sequences each line through five states:
- `ST_IDLE`: detection is disabled.
- `ST_ARMED`: enabled, waiting for the first sync start.
- `ST_WAIT`: counting toward the start pixel.
- `ST_PULSE`: the strobe is low.
- `ST_DONE`: the strobe for this line is finished.

Its transitions are:
- enable-low: any state to `ST_IDLE`.
- enable: `ST_IDLE` to `ST_ARMED`.
- sync start: `ST_ARMED`, `ST_WAIT`, `ST_PULSE` or `ST_DONE` to `ST_WAIT`.
- start reached: `ST_WAIT` to `ST_PULSE`.
- empty window: `ST_WAIT` to `ST_DONE`.
- stop reached: `ST_PULSE` to `ST_DONE`, which publishes the status.

A sync start that arrives in `ST_PULSE` also publishes the status.

Top module: `tvdet_pulse_ctrl`

## Requirements
- R1: After reset, `det_strobe_n` is 1, `load_status` is 0, `load_irq` is 0 and `coupling_out` is 0. The start and stop positions reset to 0.
- R2: A sync start is a clock edge at which `hsync` is sampled 1 after being sampled 0 at the previous edge. Call that edge E0. While enabled with start S below stop P, `det_strobe_n` is 0 exactly in the cycles that follow edges E0+S+1 through E0+P, which is P−S cycles.
- R3: If the start position is not below the stop position, `det_strobe_n` stays 1 for the whole line.
- R4: The comparator input is sampled at the sync-start edge E0 only. Changes to it later in the line do not affect the value that the line publishes.
- R5: `load_status` takes the value latched at E0 at the same edge at which the strobe returns high (edge E0+P+1). It changes at no other time.
- R6: `load_irq` is 1 for exactly one cycle, the cycle in which `load_status` changes value. Otherwise it is 0.
- R7: When `video_en` is sampled 0, `det_strobe_n` is 1 from the next cycle on and `load_status` holds its value.
- R8: Configuration writes (`cfg_we` = 1) take effect only at edges where `video_en` is 0. At other edges they are ignored.
- R9: `coupling_out` presents the stored coupling bit: 0 for DC coupled, 1 for AC coupled.
- R10: A sync start that arrives while the strobe is low ends the strobe at that edge and publishes the previous line's latched value. The new line then places its strobe again at E0+S+1.
- R11: After `video_en` rises, no strobe is produced until the first sync start has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync from the encoder, active high |
| video_en | input | 1 | Video output active; enables detection |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_coupling | input | 1 | Coupling mode to store (0 DC, 1 AC) |
| cfg_start | input | PIX_W | Start pixel position to store |
| cfg_stop | input | PIX_W | Stop pixel position to store |
| cmp_in | input | 1 | Load comparator result from the analog stage |
| det_strobe_n | output | 1 | Active-low detection strobe |
| coupling_out | output | 1 | Coupling mode forwarded to the analog stage |
| load_status | output | 1 | Published load status (1 = load present) |
| load_irq | output | 1 | One-cycle pulse on a status change |

## Verification
The bench sweeps every pair of start and stop positions from 0 to 6, including empty windows and a start of 0. For each pair it compares the strobe, the status and the interrupt cycle by cycle against arithmetic expectations. An off-by-one in the counter or the state machine would shift or stretch the strobe, and a wrong comparison would produce a strobe for an empty window. The comparator input is flipped right after the sync edge, so sampling at the wrong time would publish the wrong value. The bench also covers a sync that arrives mid-strobe, enable dropping mid-strobe, enabling partway through a line, and configuration writes attempted while enabled. A design that ignored any of these would leave the strobe low, publish while disabled, strobe a partial line, or take a new configuration while enabled.

// File: rtl/tvdet_pkg.sv
package tvdet_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_WAIT  = 3'd2,
        ST_PULSE = 3'd3,
        ST_DONE  = 3'd4
    } strobe_state_e;

    localparam logic COUPLE_DC = 1'b0;
    localparam logic COUPLE_AC = 1'b1;

endpackage

// File: rtl/tvdet_cfg_regs.sv
module tvdet_cfg_regs #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             video_en,
    input  logic             wr_en,
    input  logic             coupling_d,
    input  logic [PIX_W-1:0] start_d,
    input  logic [PIX_W-1:0] stop_d,
    output logic             coupling_q,
    output logic [PIX_W-1:0] start_q,
    output logic [PIX_W-1:0] stop_q,
    output logic             window_ok
);
    import tvdet_pkg::*;

    logic accept;

    assign accept = wr_en && !video_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coupling_q <= COUPLE_DC;
            start_q    <= '0;
            stop_q     <= '0;
        end else if (accept) begin
            coupling_q <= coupling_d;
            start_q    <= start_d;
            stop_q     <= stop_d;
        end
    end

    assign window_ok = (start_q < stop_q);

endmodule

// File: rtl/tvdet_line_counter.sv
module tvdet_line_counter #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    output logic             sync_start,
    output logic [PIX_W-1:0] pix_cnt
);
    localparam logic [PIX_W-1:0] CNT_MAX = {PIX_W{1'b1}};

    logic hsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_q <= 1'b0;
        end else begin
            hsync_q <= hsync;
        end
    end

    assign sync_start = hsync && !hsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (sync_start) begin
            pix_cnt <= '0;
        end else if (pix_cnt != CNT_MAX) begin
            pix_cnt <= pix_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tvdet_strobe_fsm.sv
module tvdet_strobe_fsm #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             video_en,
    input  logic             sync_start,
    input  logic [PIX_W-1:0] pix_cnt,
    input  logic [PIX_W-1:0] start_pos,
    input  logic [PIX_W-1:0] stop_pos,
    input  logic             window_ok,
    output logic             strobe_n,
    output logic             publish
);
    import tvdet_pkg::*;

    strobe_state_e state_q, state_d;
    logic at_start, at_stop;

    assign at_start = (pix_cnt >= start_pos);
    assign at_stop  = (pix_cnt >= stop_pos);

    always_comb begin
        state_d = state_q;
        if (!video_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ARMED;
                ST_ARMED: if (sync_start) state_d = ST_WAIT;
                ST_WAIT: begin
                    if (sync_start)      state_d = ST_WAIT;
                    else if (!window_ok) state_d = ST_DONE;
                    else if (at_start)   state_d = ST_PULSE;
                end
                ST_PULSE: begin
                    if (sync_start)   state_d = ST_WAIT;
                    else if (at_stop) state_d = ST_DONE;
                end
                ST_DONE:  if (sync_start) state_d = ST_WAIT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        strobe_n = 1'b1;
        publish  = 1'b0;
        unique case (state_q)
            ST_PULSE: begin
                strobe_n = 1'b0;
                publish  = video_en && (sync_start || at_stop);
            end
            ST_IDLE, ST_ARMED, ST_WAIT, ST_DONE: begin
                strobe_n = 1'b1;
            end
            default: strobe_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/tvdet_status_capture.sv
module tvdet_status_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic video_en,
    input  logic sync_start,
    input  logic publish,
    input  logic cmp_in,
    output logic status,
    output logic irq
);
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (video_en && sync_start) begin
            held_q <= cmp_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
            irq    <= 1'b0;
        end else if (publish) begin
            status <= held_q;
            irq    <= (held_q != status);
        end else begin
            irq    <= 1'b0;
        end
    end

endmodule

// File: rtl/tvdet_pulse_ctrl.sv
module tvdet_pulse_ctrl #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             video_en,
    input  logic             cfg_we,
    input  logic             cfg_coupling,
    input  logic [PIX_W-1:0] cfg_start,
    input  logic [PIX_W-1:0] cfg_stop,
    input  logic             cmp_in,
    output logic             det_strobe_n,
    output logic             coupling_out,
    output logic             load_status,
    output logic             load_irq
);
    logic [PIX_W-1:0] start_q, stop_q, pix_cnt;
    logic             window_ok, sync_start, publish;

    tvdet_cfg_regs #(.PIX_W(PIX_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .video_en   (video_en),
        .wr_en      (cfg_we),
        .coupling_d (cfg_coupling),
        .start_d    (cfg_start),
        .stop_d     (cfg_stop),
        .coupling_q (coupling_out),
        .start_q    (start_q),
        .stop_q     (stop_q),
        .window_ok  (window_ok)
    );

    tvdet_line_counter #(.PIX_W(PIX_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .sync_start (sync_start),
        .pix_cnt    (pix_cnt)
    );

    tvdet_strobe_fsm #(.PIX_W(PIX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .video_en   (video_en),
        .sync_start (sync_start),
        .pix_cnt    (pix_cnt),
        .start_pos  (start_q),
        .stop_pos   (stop_q),
        .window_ok  (window_ok),
        .strobe_n   (det_strobe_n),
        .publish    (publish)
    );

    tvdet_status_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .video_en   (video_en),
        .sync_start (sync_start),
        .publish    (publish),
        .cmp_in     (cmp_in),
        .status     (load_status),
        .irq        (load_irq)
    );

endmodule

// File: rtl/tvdet_pulse_ctrl_chk.sv
module tvdet_pulse_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic video_en,
    input logic det_strobe_n,
    input logic coupling_out,
    input logic load_status,
    input logic load_irq
);
    assert_irq_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_irq |-> (load_status != $past(load_status)));

    assert_change_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_status != $past(load_status)) |-> load_irq);

    assert_status_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_status != $past(load_status)) |-> $rose(det_strobe_n));

    assert_disabled_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> det_strobe_n);

    assert_strobe_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !det_strobe_n |-> $past(video_en));

    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(video_en) |-> $stable(coupling_out));

endmodule

bind tvdet_pulse_ctrl tvdet_pulse_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .video_en     (video_en),
    .det_strobe_n (det_strobe_n),
    .coupling_out (coupling_out),
    .load_status  (load_status),
    .load_irq     (load_irq)
);

// File: tb/test_tvdet_pulse_ctrl.sv
`timescale 1ns/1ps
module test_tvdet_pulse_ctrl;
    localparam int PW = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hsync = 0, video_en = 0, cfg_we = 0, cfg_coupling = 0, cmp_in = 0;
    logic [PW-1:0] cfg_start = '0, cfg_stop = '0;
    logic det_strobe_n, coupling_out, load_status, load_irq;

    int checks = 0, errors = 0;
    logic exp_status = 1'b0;

    always #2 clk = ~clk;

    tvdet_pulse_ctrl #(.PIX_W(PW)) i_tvdet_pulse_ctrl (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .video_en(video_en),
        .cfg_we(cfg_we), .cfg_coupling(cfg_coupling), .cfg_start(cfg_start),
        .cfg_stop(cfg_stop), .cmp_in(cmp_in), .det_strobe_n(det_strobe_n),
        .coupling_out(coupling_out), .load_status(load_status), .load_irq(load_irq)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input int s, input int p, input logic cpl);
        video_en = 0;
        step();
        cfg_we = 1; cfg_start = PW'(s); cfg_stop = PW'(p); cfg_coupling = cpl;
        step();
        cfg_we = 0;
        chk(coupling_out, cpl, "R9 coupling forwarded");
    endtask

    // Runs one line from a sync start; checks strobe, status, irq per cycle
    task automatic run_line(input int s, input int p, input logic c, input int len);
        logic old;
        bit pulse;
        old = exp_status;
        pulse = (s < p);
        hsync = 1; cmp_in = c;
        for (int k = 0; k < len; k++) begin
            step();
            if (k == 0) cmp_in = ~c;       // R4: later changes must not matter
            if (k == 1) hsync = 0;
            chk(det_strobe_n, !(pulse && k >= s + 1 && k <= p),
                pulse ? "R2 strobe window" : "R3 empty window");
            if (pulse && k >= p + 1) exp_status = c;
            chk(load_status, exp_status, "R4/R5 status");
            chk(load_irq, pulse && k == p + 1 && c != old, "R6 irq");
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        chk(det_strobe_n, 1'b1, "R1 reset strobe");
        chk(load_status, 1'b0, "R1 reset status");
        chk(load_irq, 1'b0, "R1 reset irq");
        chk(coupling_out, 1'b0, "R1 reset coupling");

        // R2/R3/R4/R5/R6: exhaustive sweep of start/stop
        for (int s = 0; s <= 6; s++) begin
            for (int p = 0; p <= 6; p++) begin
                write_cfg(s, p, 1'((s + p) & 1));
                video_en = 1;
                step();
                run_line(s, p, 1'((s * 7 + p) % 3 == 0 ? 0 : 1) ^ exp_status, 10);
            end
        end

        // R8: write while enabled is ignored
        write_cfg(1, 3, 1'b0);
        video_en = 1;
        step();
        cfg_we = 1; cfg_start = PW'(4); cfg_stop = PW'(6); cfg_coupling = 1'b1;
        step();
        cfg_we = 0;
        chk(coupling_out, 1'b0, "R8 coupling write ignored");
        run_line(1, 3, ~exp_status, 8);

        // R10: sync arriving mid-strobe
        begin
            logic c1;
            c1 = ~exp_status;
            write_cfg(1, 8, 1'b1);
            video_en = 1;
            step();
            hsync = 1; cmp_in = c1;
            for (int k = 0; k <= 3; k++) begin
                step();
                if (k == 0) cmp_in = ~c1;
                if (k == 1) hsync = 0;
                chk(det_strobe_n, !(k >= 2), "R10 first line strobe");
            end
            hsync = 1; cmp_in = ~c1;
            step();
            chk(det_strobe_n, 1'b1, "R10 strobe ends at new sync");
            chk(load_status, c1, "R10 publish previous latch");
            chk(load_irq, c1 != exp_status, "R10 irq");
            exp_status = c1;
            hsync = 0;
            step(); step();
            chk(det_strobe_n, 1'b0, "R10 new line strobe restarts");
        end

        // R7: disable mid-strobe
        write_cfg(1, 6, 1'b0);
        video_en = 1;
        step();
        hsync = 1; cmp_in = ~exp_status;
        for (int k = 0; k <= 3; k++) begin
            step();
            if (k == 1) hsync = 0;
        end
        chk(det_strobe_n, 1'b0, "R7 strobe low before disable");
        video_en = 0;
        for (int k = 0; k < 8; k++) begin
            step();
            chk(det_strobe_n, 1'b1, "R7 strobe high when disabled");
            chk(load_status, exp_status, "R7 status held");
        end
        hsync = 1;
        step(); step();
        hsync = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            chk(det_strobe_n, 1'b1, "R7 no strobe on disabled line");
        end

        // R11: enabling mid-line waits for sync
        write_cfg(0, 3, 1'b0);
        video_en = 1;
        for (int k = 0; k < 6; k++) begin
            step();
            chk(det_strobe_n, 1'b1, "R11 no strobe before sync");
        end
        run_line(0, 3, ~exp_status, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule